// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the combinational arithmetic and logic core of a small 8-bit accumulator machine. In one evaluation it takes an operation code, the accumulator, an operand byte and the present five condition flags (sign, zero, auxiliary carry, parity, carry). It returns the new accumulator and the new flags. The surrounding sequencer keeps the accumulator and flag registers and loads them from these outputs.

Two further outputs are always live. The first reports whether one of eight flag conditions holds, which the sequencer uses for conditional branches. The second is the present flags packed into a status byte with a fixed layout, ready to save on a stack. A restore operation does the reverse and unpacks such a byte back into the flags. The alternate-parity mode input covers processors that report parity as zero after arithmetic.

Top module: `acc_alu`

## Requirements
- R1: Operation codes 0..3 perform add, add with carry-in, subtract and subtract with borrow-in. The carry-in and borrow-in are the incoming C flag and are used only by codes 1 and 3. C takes bit 8 of the 9-bit result, which signals the borrow for subtracts. S takes bit 7. Z is set when the low 8 bits are zero. The accumulator receives the low 8 bits.
- R2: Code 7 (compare) sets every flag exactly as subtract does, but leaves the accumulator output equal to the accumulator input.
- R3: P is 1 when the 8-bit result holds an even number of ones and 0 when it holds an odd number. When the alternate-parity mode input is high, P is 0 after codes 0..3, 7, 8 and 9. The mode input has no effect on the flags of any other code.
- R4: For codes 0..3 and 7, AC is the carry out of bit 3 on an add and the borrow into bit 4 on a subtract. The incoming carry or borrow is included in both cases.
- R5: Codes 4, 5 and 6 produce AND, XOR and OR of accumulator and operand. They clear C and AC and set S, Z and P from the result.
- R6: Codes 8 and 9 increment and decrement the accumulator. They set S, Z and P from the result and pass C and AC through unchanged.
- R7: Codes 10..13 rotate the accumulator and change only C:
  - Code 10 copies bit 7 into both C and bit 0.
  - Code 11 copies bit 0 into both C and bit 7.
  - Code 12 moves the old C into bit 0 and bit 7 into C.
  - Code 13 moves the old C into bit 7 and bit 0 into C.
- R8: Code 14 is the decimal adjust, performed in two steps:
  - If the low nibble is above 9 or AC is set, 6 is added to the byte, and the new AC is the carry out of bit 3 of that addition (otherwise the new AC is 0).
  - If the high nibble of that sum is above 9 or the new AC is set, 0x60 is added.
  - C is bit 8 of the total. S, Z and P follow the result, with P never forced to 0.
- R9: Code 15 inverts the accumulator and leaves the flags unchanged. Code 16 inverts C. Code 17 sets C. Neither code 16 nor code 17 changes the accumulator or the other flags.
- R10: The status output packs the incoming flags as S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and C at bit 0. Bit 1 is always 1, and bits 5 and 3 are always 0.
- R11: Code 18 leaves the accumulator unchanged and loads the flags from the operand using the R10 bit positions.
- R12: The condition output for selector 0..7 is, in order: Z clear, Z set, C clear, C set, P clear, P set, S clear, S set.
- R13: Codes 19..31 pass the accumulator and all flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| alt_mode_i | input | 1 | Force P to 0 after arithmetic, increment and decrement |
| acc_i | input | 8 | Present accumulator |
| opnd_i | input | 8 | Operand byte, or status byte for restore |
| flags_i | input | 5 | Present flags, bit 4 S, 3 Z, 2 AC, 1 P, 0 C |
| cond_sel_i | input | 3 | Condition selector |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 5 | New flags, same layout as flags_i |
| cond_o | output | 1 | Selected condition holds |
| status_o | output | 8 | Packed status byte of flags_i |

## Verification
The bench sweeps every accumulator value against a spread of operands, under four flag patterns and both parity modes, and compares against a model written from the requirements.

Each corner case targets a specific kind of error:
- Subtract-with-borrow at zero operands catches a borrow taken from the wrong flag or inverted.
- The nibble boundaries 0x0F/0x10 expose an auxiliary carry taken from the wrong bit.
- Decimal adjust with AC set on a low nibble of 0..9 catches a design that tests only the nibble value.
- Alternate-parity mode paired with the logical ops and decimal adjust catches a design that forces parity to zero there too.

The status and condition sweeps cover all 32 flag combinations, so a swapped bit position or a swapped condition pair shows up directly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;
    localparam int CSW = 3;
    localparam int FW  = 5;

    localparam int STB_S   = 7;
    localparam int STB_Z   = 6;
    localparam int STB_AC  = 4;
    localparam int STB_P   = 2;
    localparam int STB_ONE = 1;
    localparam int STB_C   = 0;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic c;
    } flags_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_AND  = 5'd4,
        OP_XOR  = 5'd5,
        OP_OR   = 5'd6,
        OP_CMP  = 5'd7,
        OP_INC  = 5'd8,
        OP_DEC  = 5'd9,
        OP_RLC  = 5'd10,
        OP_RRC  = 5'd11,
        OP_RAL  = 5'd12,
        OP_RAR  = 5'd13,
        OP_DAA  = 5'd14,
        OP_CMA  = 5'd15,
        OP_CMC  = 5'd16,
        OP_STC  = 5'd17,
        OP_RSTF = 5'd18
    } op_e;

    function automatic logic even_ones(byte_t v);
        return ~(^v);
    endfunction

    function automatic logic uses_addsub(op_e o);
        return o inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_CMP};
    endfunction

    function automatic byte_t pack_status(flags_t f);
        byte_t r;
        r          = '0;
        r[STB_S]   = f.s;
        r[STB_Z]   = f.z;
        r[STB_AC]  = f.ac;
        r[STB_P]   = f.p;
        r[STB_ONE] = 1'b1;
        r[STB_C]   = f.c;
        return r;
    endfunction

    function automatic flags_t unpack_status(byte_t b);
        flags_t f;
        f.s  = b[STB_S];
        f.z  = b[STB_Z];
        f.ac = b[STB_AC];
        f.p  = b[STB_P];
        f.c  = b[STB_C];
        return f;
    endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
// Two-operand group: add/subtract family, compare and bitwise logic.
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  op_e    op,
    input  logic   alt_mode,
    input  byte_t  a,
    input  byte_t  b,
    input  logic   c_in,
    output byte_t  res,
    output flags_t fl
);
    logic          is_sub;
    logic          cin;
    logic [DW:0]   wide;
    logic [NW:0]   nib;
    byte_t         lres;

    always_comb begin
        is_sub = op inside {OP_SUB, OP_SBB, OP_CMP};
        cin    = (op == OP_ADC || op == OP_SBB) ? c_in : 1'b0;
        if (is_sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            nib  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            nib  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end

        case (op)
            OP_AND:  lres = a & b;
            OP_XOR:  lres = a ^ b;
            default: lres = a | b;
        endcase

        if (op inside {OP_AND, OP_XOR, OP_OR}) begin
            res   = lres;
            fl.c  = 1'b0;
            fl.ac = 1'b0;
            fl.s  = lres[DW-1];
            fl.z  = (lres == '0);
            fl.p  = even_ones(lres);
        end else begin
            res   = (op == OP_CMP) ? a : wide[DW-1:0];
            fl.c  = wide[DW];
            fl.ac = nib[NW];
            fl.s  = wide[DW-1];
            fl.z  = (wide[DW-1:0] == '0);
            fl.p  = alt_mode ? 1'b0 : even_ones(wide[DW-1:0]);
        end
    end
endmodule

// File: rtl/acc_alu_unary.sv
// Single-operand group: step, rotate, decimal adjust, carry control, flag restore.
module acc_alu_unary
    import acc_alu_pkg::*;
(
    input  op_e    op,
    input  logic   alt_mode,
    input  byte_t  a,
    input  byte_t  b,
    input  flags_t fin,
    output byte_t  res,
    output flags_t fl
);
    byte_t       step;
    logic        lo_fix, hi_fix, ac_n;
    logic [NW:0] nib6;
    logic [DW:0] s1, tot;

    always_comb begin
        step   = (op == OP_DEC) ? a - 1'b1 : a + 1'b1;
        lo_fix = (a[NW-1:0] > 4'd9) || fin.ac;
        nib6   = {1'b0, a[NW-1:0]} + 5'd6;
        ac_n   = lo_fix & nib6[NW];
        s1     = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
        hi_fix = (s1[DW-1:NW] > 4'd9) || ac_n;
        tot    = s1 + (hi_fix ? 9'h060 : 9'h000);

        res = a;
        fl  = fin;
        case (op)
            OP_INC, OP_DEC: begin
                res  = step;
                fl.s = step[DW-1];
                fl.z = (step == '0);
                fl.p = alt_mode ? 1'b0 : even_ones(step);
            end
            OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; fl.c = a[DW-1]; end
            OP_RRC: begin res = {a[0], a[DW-1:1]};    fl.c = a[0];    end
            OP_RAL: begin res = {a[DW-2:0], fin.c};   fl.c = a[DW-1]; end
            OP_RAR: begin res = {fin.c, a[DW-1:1]};   fl.c = a[0];    end
            OP_DAA: begin
                res   = tot[DW-1:0];
                fl.c  = tot[DW];
                fl.ac = ac_n;
                fl.s  = tot[DW-1];
                fl.z  = (tot[DW-1:0] == '0);
                fl.p  = even_ones(tot[DW-1:0]);
            end
            OP_CMA:  res  = ~a;
            OP_CMC:  fl.c = ~fin.c;
            OP_STC:  fl.c = 1'b1;
            OP_RSTF: fl   = unpack_status(b);
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_cond.sv
// Condition test and status-byte packing from the present flags.
module acc_alu_cond
    import acc_alu_pkg::*;
(
    input  flags_t          fin,
    input  logic [CSW-1:0]  sel,
    output logic            hit,
    output byte_t           stat
);
    logic picked;

    always_comb begin
        case (sel[CSW-1:1])
            2'd0:    picked = fin.z;
            2'd1:    picked = fin.c;
            2'd2:    picked = fin.p;
            default: picked = fin.s;
        endcase
        // odd selector tests the flag set, even selector tests it clear
        hit  = sel[0] ? picked : ~picked;
        stat = pack_status(fin);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic           alt_mode_i,
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  opnd_i,
    input  logic [FW-1:0]  flags_i,
    input  logic [CSW-1:0] cond_sel_i,
    output logic [DW-1:0]  acc_o,
    output logic [FW-1:0]  flags_o,
    output logic           cond_o,
    output logic [DW-1:0]  status_o
);
    op_e    op;
    flags_t fin;
    byte_t  as_res, un_res;
    flags_t as_fl, un_fl;

    assign op  = op_e'(op_i);
    assign fin = flags_t'(flags_i);

    acc_alu_addsub u_addsub (
        .op       (op),
        .alt_mode (alt_mode_i),
        .a        (acc_i),
        .b        (opnd_i),
        .c_in     (fin.c),
        .res      (as_res),
        .fl       (as_fl)
    );

    acc_alu_unary u_unary (
        .op       (op),
        .alt_mode (alt_mode_i),
        .a        (acc_i),
        .b        (opnd_i),
        .fin      (fin),
        .res      (un_res),
        .fl       (un_fl)
    );

    acc_alu_cond u_cond (
        .fin  (fin),
        .sel  (cond_sel_i),
        .hit  (cond_o),
        .stat (status_o)
    );

    always_comb begin
        if (uses_addsub(op)) begin
            acc_o   = as_res;
            flags_o = as_fl;
        end else begin
            acc_o   = un_res;
            flags_o = un_fl;
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic [OPW-1:0] op_i,
    input logic           alt_mode_i,
    input logic [DW-1:0]  acc_i,
    input logic [DW-1:0]  opnd_i,
    input logic [FW-1:0]  flags_i,
    input logic [CSW-1:0] cond_sel_i,
    input logic [DW-1:0]  acc_o,
    input logic [FW-1:0]  flags_o,
    input logic           cond_o,
    input logic [DW-1:0]  status_o
);
    always_comb begin
        if (!$isunknown({op_i, alt_mode_i, acc_i, opnd_i, flags_i, cond_sel_i})) begin
            if (op_i == 5'd7)
                p_cmp_keeps_acc_r2: assert (acc_o == acc_i)
                    else $error("compare changed accumulator");
            if (alt_mode_i && (op_i <= 5'd3 || op_i == 5'd7 || op_i == 5'd8 || op_i == 5'd9))
                p_alt_parity_zero_r3: assert (flags_o[1] == 1'b0)
                    else $error("parity not forced in alternate mode");
            if (op_i >= 5'd4 && op_i <= 5'd6)
                p_logic_clears_r5: assert (flags_o[0] == 1'b0 && flags_o[2] == 1'b0)
                    else $error("logic op left C or AC set");
            if (op_i == 5'd8 || op_i == 5'd9)
                p_step_keeps_c_r6: assert (flags_o[0] == flags_i[0] && flags_o[2] == flags_i[2])
                    else $error("step changed C or AC");
            if (op_i == 5'd16)
                p_cmc_inverts_r9: assert (flags_o == (flags_i ^ 5'b00001) && acc_o == acc_i)
                    else $error("carry complement wrong");
            p_status_fixed_bits_r10: assert (status_o[1] && !status_o[3] && !status_o[5])
                else $error("status constant bits wrong");
            if (op_i == 5'd18)
                p_restore_r11: assert (acc_o == acc_i && flags_o[0] == opnd_i[0] && flags_o[4] == opnd_i[7])
                    else $error("restore wrong");
            if (cond_sel_i == 3'd1)
                p_cond_zero_r12: assert (cond_o == flags_i[3])
                    else $error("zero condition wrong");
            if (op_i >= 5'd19)
                p_unused_pass_r13: assert (acc_o == acc_i && flags_o == flags_i)
                    else $error("unused code altered state");
        end
    end
endmodule

bind acc_alu acc_alu_chk u_chk (
    .op_i       (op_i),
    .alt_mode_i (alt_mode_i),
    .acc_i      (acc_i),
    .opnd_i     (opnd_i),
    .flags_i    (flags_i),
    .cond_sel_i (cond_sel_i),
    .acc_o      (acc_o),
    .flags_o    (flags_o),
    .cond_o     (cond_o),
    .status_o   (status_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic       alt_mode_i = 1'b0;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic [4:0] flags_i = '0;
    logic [2:0] cond_sel_i = '0;
    logic [7:0] acc_o, status_o;
    logic [4:0] flags_o;
    logic       cond_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .op_i(op_i), .alt_mode_i(alt_mode_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .flags_i(flags_i), .cond_sel_i(cond_sel_i), .acc_o(acc_o),
        .flags_o(flags_o), .cond_o(cond_o), .status_o(status_o)
    );

    function automatic int ones(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    function automatic string tag_of(int op);
        if (op <= 3) return "R1";
        if (op == 7) return "R2";
        if (op <= 6) return "R5";
        if (op <= 9) return "R6";
        if (op <= 13) return "R7";
        if (op == 14) return "R8";
        if (op <= 17) return "R9";
        if (op == 18) return "R11";
        return "R13";
    endfunction

    // returns {acc[7:0], S, Z, AC, P, C}
    function automatic logic [12:0] model(int op, int a, int b, logic [4:0] f, bit alt);
        int s = f[4], z = f[3], ac = f[2], p = f[1], c = f[0];
        int r = a, t, cin, lo, nac;
        bit upd = 0;            // recompute S, Z from r
        bit par_forced = 0;     // arithmetic-type parity (R3)
        case (op)
            0, 1, 2, 3, 7: begin
                cin = (op == 1 || op == 3) ? c : 0;
                if (op <= 1) begin
                    t  = a + b + cin;
                    ac = ((a % 16) + (b % 16) + cin) > 15;   // R4 add
                end else begin
                    t  = a - b - cin;
                    ac = (a % 16) < ((b % 16) + cin);        // R4 subtract
                end
                c = (t < 0 || t > 255);
                r = t & 255; upd = 1; par_forced = 1;
            end
            4: begin r = a & b; c = 0; ac = 0; upd = 1; end
            5: begin r = a ^ b; c = 0; ac = 0; upd = 1; end
            6: begin r = a | b; c = 0; ac = 0; upd = 1; end
            8: begin r = (a + 1) & 255; upd = 1; par_forced = 1; end
            9: begin r = (a + 255) & 255; upd = 1; par_forced = 1; end
            10: begin c = a / 128; r = (a * 2) % 256 + c; end
            11: begin c = a % 2; r = a / 2 + c * 128; end
            12: begin r = (a * 2) % 256 + c; c = a / 128; end
            13: begin r = a / 2 + c * 128; c = a % 2; end
            14: begin
                lo = a % 16; nac = 0; t = a;
                if (lo > 9 || ac != 0) begin t = a + 6; nac = (lo + 6) > 15; end
                if (((t / 16) % 16) > 9 || nac != 0) t = t + 96;
                c = t > 255; ac = nac; r = t % 256; upd = 1;
            end
            15: r = 255 - a;
            16: c = 1 - c;
            17: c = 1;
            18: begin s = (b >> 7) & 1; z = (b >> 6) & 1; ac = (b >> 4) & 1;
                      p = (b >> 2) & 1; c = b & 1; end
            default: ;
        endcase
        if (upd) begin
            s = r / 128; z = (r == 0);
            p = (ones(r) % 2) == 0;
            if (par_forced && alt) p = 0;
        end
        if (op == 7) r = a;
        return {r[7:0], s[0], z[0], ac[0], p[0], c[0]};
    endfunction

    task automatic check_op(int op, int a, int b, logic [4:0] f, bit alt);
        logic [12:0] exp;
        op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f; alt_mode_i = alt;
        #1;
        exp = model(op, a, b, f, alt);
        checks++;
        if ({acc_o, flags_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h f=%05b alt=%0d actual acc=%02h fl=%05b expected acc=%02h fl=%05b",
                     tag_of(op), op, a, b, f, alt, acc_o, flags_o, exp[12:5], exp[4:0]);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] fpat [4];
        logic       exp_c;
        logic [7:0] exp_st;
        fpat[0] = 5'b00000; fpat[1] = 5'b11111; fpat[2] = 5'b00100; fpat[3] = 5'b00001;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zeroed inputs give 0+0, Z and P set (R1, R3)
        checks++;
        if (acc_o !== 8'h00 || flags_o !== 5'b01010) begin
            errors++;
            $display("FAIL R1 reset actual acc=%02h fl=%05b expected acc=00 fl=01010", acc_o, flags_o);
        end
        // main sweep over all codes, accumulator values, flag patterns, both modes
        for (int op = 0; op < 32; op++)
            for (int a = 0; a < 256; a++)
                for (int fi = 0; fi < 4; fi++)
                    for (int alt = 0; alt < 2; alt++)
                        if (op < 8 || op == 18)
                            for (int b = 0; b < 256; b += 17) check_op(op, a, b, fpat[fi], alt[0]);
                        else
                            check_op(op, a, (a * 37 + 11) % 256, fpat[fi], alt[0]);
        // nibble and borrow boundaries, R4 and R1
        check_op(0, 8'h0F, 8'h01, 5'b00000, 0);
        check_op(1, 8'h0F, 8'h00, 5'b00001, 0);
        check_op(2, 8'h10, 8'h01, 5'b00000, 0);
        check_op(3, 8'h00, 8'h00, 5'b00001, 0);
        check_op(7, 8'h05, 8'h05, 5'b00000, 1);
        // status packing (R10) and condition test (R12) over all flags
        for (int f = 0; f < 32; f++) begin
            for (int sel = 0; sel < 8; sel++) begin
                flags_i = f[4:0]; cond_sel_i = sel[2:0]; op_i = 5'd31;
                #1;
                case (sel)
                    0: exp_c = !f[3]; 1: exp_c = f[3];
                    2: exp_c = !f[0]; 3: exp_c = f[0];
                    4: exp_c = !f[1]; 5: exp_c = f[1];
                    6: exp_c = !f[4]; default: exp_c = f[4];
                endcase
                checks++;
                if (cond_o !== exp_c) begin
                    errors++;
                    $display("FAIL R12 f=%05b sel=%0d actual %0b expected %0b", f, sel, cond_o, exp_c);
                end
            end
            exp_st = {f[4], f[3], 1'b0, f[2], 1'b0, f[1], 1'b1, f[0]};
            checks++;
            if (status_o !== exp_st) begin
                errors++;
                $display("FAIL R10 f=%05b actual %02h expected %02h", f, status_o, exp_st);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule